// File: doc/BRIEF.md
# Fixed-Point DSP Arithmetic Logic Unit

This block is the integer arithmetic and logic stage of a DSP datapath. Each cycle it takes two signed two's-complement operands, a carry input, a five-bit operation code and a saturation-mode bit. The result and the status flags are combinational. A register-file write strobe tells the surrounding datapath whether the result should be stored. A dual operation yields the sum and the difference at the same time on two result ports, each with its own write strobe.

The block covers plain, carry and borrow additions, an averaging add, a compare that stores nothing, one-operand forms, signed minimum and maximum, clipping to a symmetric bound, and bitwise logic. When saturation is on, signed overflow clamps to the most positive or most negative value. A sticky overflow bit records every overflow seen while an operation executes, and holds until a dedicated clear input drops it.

Top module: `fxalu`

## Requirements
- R1: With exec_en high, opcode 0 gives rx+ry, opcode 1 gives rx-ry, opcode 3 gives rx+ry+ci and opcode 4 gives rx-ry+ci-1, on res_a with wr_a high in the same cycle.
- R2: Opcode 2 drives rx+ry on res_a and rx-ry on res_b, with both wr_a and wr_b high. wr_b is low for every other opcode.
- R3: Opcode 5 returns (rx+ry)/2, computed on a sign-extended 33-bit sum and shifted right arithmetically, so it never overflows (flag_v low).
- R4: Opcode 6 compares by computing rx-ry for the flags only and holds wr_a low. Codes 21 to 31 also hold wr_a low.
- R5: The one-operand opcodes are 7 negate, 8 absolute value, 9 pass, 13 rx+ci, 14 rx+ci-1, 15 rx+1 and 16 rx-1.
- R6: Opcode 10 returns the signed minimum of rx and ry, and opcode 11 returns the signed maximum.
- R7: Opcode 12 clips rx to the range from -|ry| to +|ry|. It returns |ry| when rx exceeds that bound, -|ry| when rx is below the negated bound, and rx otherwise.
- R8: Opcodes 17, 18, 19 and 20 give rx AND ry, rx OR ry, rx XOR ry and NOT rx.
- R9: With sat_en high, a signed overflow on res_a or res_b returns 0x7FFFFFFF for a positive true result and 0x80000000 for a negative one. With sat_en low, the result wraps.
- R10: flag_z is high when the result (the difference for a compare, the sum for the dual operation) is zero, and flag_n is its bit 31. flag_v is signed overflow; for the dual operation it is the OR of both overflows. flag_c is the carry out of bit 31 of the adder, which for subtraction means no borrow; it is zero for non-adder operations.
- R11: sticky_v goes high at the clock edge after a cycle with exec_en and flag_v both high, and holds until clr_sticky. If a clear and a new overflow arrive in the same cycle, the bit ends up set.
- R12: After reset, sticky_v is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | An operation executes this cycle |
| opcode | input | 5 | Operation code |
| rx | input | 32 | First operand |
| ry | input | 32 | Second operand |
| ci | input | 1 | Carry input |
| sat_en | input | 1 | Saturation mode |
| clr_sticky | input | 1 | Clears the sticky overflow bit |
| res_a | output | 32 | Primary result |
| res_b | output | 32 | Difference for the dual operation |
| wr_a | output | 1 | Store res_a |
| wr_b | output | 1 | Store res_b |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| sticky_v | output | 1 | Sticky overflow |

## Verification
The results, write strobes and the four flags are combinational, so they are valid in the same cycle as the operands. The bench drives inputs just after a falling edge and samples one time unit later, before the next rising edge. sticky_v is the only registered output and changes at the rising edge after the operation, so sticky checks wait past that edge before they sample. Every expected value is a literal worked out by hand from the requirements.

// File: rtl/fxalu.sv
module fxalu #(
  parameter int W   = 32,
  parameter int OPW = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_en,
  input  logic [OPW-1:0] opcode,
  input  logic [W-1:0] rx,
  input  logic [W-1:0] ry,
  input  logic         ci,
  input  logic         sat_en,
  input  logic         clr_sticky,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_b,
  output logic         wr_a,
  output logic         wr_b,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_c,
  output logic         sticky_v
);
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [OPW-1:0] OP_ADD = OPW'(0),  OP_SUB = OPW'(1),  OP_DUAL = OPW'(2),
                             OP_ADC = OPW'(3),  OP_SBB = OPW'(4),  OP_AVG  = OPW'(5),
                             OP_CMP = OPW'(6),  OP_NEG = OPW'(7),  OP_ABS  = OPW'(8),
                             OP_PAS = OPW'(9),  OP_MIN = OPW'(10), OP_MAX  = OPW'(11),
                             OP_CLP = OPW'(12), OP_INC = OPW'(13), OP_DCC  = OPW'(14),
                             OP_IN1 = OPW'(15), OP_DE1 = OPW'(16), OP_AND  = OPW'(17),
                             OP_OR  = OPW'(18), OP_XOR = OPW'(19), OP_NOT  = OPW'(20);

  logic [W-1:0] add_a, add_b, res;
  logic         add_c, use_add, v, c;
  logic [W:0]   sum, dif;

  always_comb begin
    add_a = rx; add_b = ZERO; add_c = 1'b0; use_add = 1'b1;
    case (opcode)
      OP_ADD, OP_DUAL: add_b = ry;
      OP_SUB, OP_CMP:  begin add_b = ~ry; add_c = 1'b1; end
      OP_ADC:          begin add_b = ry;  add_c = ci;   end
      OP_SBB:          begin add_b = ~ry; add_c = ci;   end
      OP_NEG:          begin add_a = ZERO; add_b = ~rx; add_c = 1'b1; end
      OP_INC:          add_c = ci;
      OP_DCC:          begin add_b = ONES; add_c = ci; end
      OP_IN1:          add_c = 1'b1;
      OP_DE1:          add_b = ONES;
      default:         use_add = 1'b0;
    endcase
  end

  assign sum = {1'b0, add_a} + {1'b0, add_b} + {{W{1'b0}}, add_c};
  assign dif = {1'b0, rx} + {1'b0, ~ry} + {{W{1'b0}}, 1'b1};

  wire add_ov = (add_a[W-1] == add_b[W-1]) && (sum[W-1] != add_a[W-1]);
  wire sub_ov = (rx[W-1] != ry[W-1]) && (dif[W-1] != rx[W-1]);
  wire abs_ov = (rx == MINN);
  wire [W:0] avg_s = {rx[W-1], rx} + {ry[W-1], ry};

  logic signed [W:0] xs, ys, bnd;
  assign xs  = $signed({rx[W-1], rx});
  assign ys  = $signed({ry[W-1], ry});
  assign bnd = ys[W] ? -ys : ys;
  wire signed [W:0] nbnd = -bnd;

  always_comb begin
    res = rx; v = 1'b0; c = 1'b0;
    if (use_add) begin
      v = add_ov;
      c = sum[W];
      res = (sat_en && add_ov) ? (add_a[W-1] ? MINN : MAXP) : sum[W-1:0];
      if (opcode == OP_DUAL) v = add_ov | sub_ov;
    end else begin
      case (opcode)
        OP_AVG: res = avg_s[W:1];
        OP_ABS: begin
          v = abs_ov;
          if (abs_ov) res = sat_en ? MAXP : MINN;
          else        res = rx[W-1] ? (ZERO - rx) : rx;
        end
        OP_MIN: res = ($signed(rx) < $signed(ry)) ? rx : ry;
        OP_MAX: res = ($signed(rx) > $signed(ry)) ? rx : ry;
        OP_CLP: begin
          if (xs > bnd)       res = bnd[W-1:0];
          else if (xs < nbnd) res = nbnd[W-1:0];
          else                res = rx;
        end
        OP_AND: res = rx & ry;
        OP_OR:  res = rx | ry;
        OP_XOR: res = rx ^ ry;
        OP_NOT: res = ~rx;
        default: res = rx;
      endcase
    end
  end

  assign res_a  = res;
  assign res_b  = (sat_en && sub_ov) ? (rx[W-1] ? MINN : MAXP) : dif[W-1:0];
  assign wr_a   = exec_en && (opcode <= OP_NOT) && (opcode != OP_CMP);
  assign wr_b   = exec_en && (opcode == OP_DUAL);
  assign flag_z = (res == ZERO);
  assign flag_n = res[W-1];
  assign flag_v = v;
  assign flag_c = c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_v <= 1'b0;
    else        sticky_v <= (sticky_v & ~clr_sticky) | (exec_en & v);
  end

  p_sticky_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && flag_v) |=> sticky_v);
  p_sticky_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sticky && !(exec_en && flag_v)) |=> !sticky_v);
  p_sticky_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_sticky && !(exec_en && flag_v)) |=> $stable(sticky_v));
  p_sat_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_en && flag_v && wr_a && opcode != OP_DUAL) |-> (res_a == MAXP || res_a == MINN));
  p_dual_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && !sat_en) |-> (res_a + res_b == {rx[W-2:0], 1'b0}));
  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_CMP) |-> !wr_a && !wr_b);
endmodule

// File: tb/fxalu_bench.sv
module fxalu_bench;
  logic clk = 0, rst_n = 0, exec_en = 0, ci = 0, sat_en = 0, clr_sticky = 0;
  logic [4:0]  opcode = 0;
  logic [31:0] rx = 0, ry = 0;
  logic [31:0] res_a, res_b;
  logic wr_a, wr_b, flag_z, flag_n, flag_v, flag_c, sticky_v;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fxalu u_fxalu (.clk, .rst_n, .exec_en, .opcode, .rx, .ry, .ci, .sat_en, .clr_sticky,
    .res_a, .res_b, .wr_a, .wr_b, .flag_z, .flag_n, .flag_v, .flag_c, .sticky_v);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(logic [4:0] op, logic [31:0] x, logic [31:0] y, logic c, logic s);
    @(negedge clk);
    opcode = op; rx = x; ry = y; ci = c; sat_en = s; exec_en = 1;
    #1;
  endtask

  task automatic t_reset;
    chk("R12 sticky after reset", 32'(sticky_v), 0);
  endtask

  task automatic t_arith;
    run(0, 5, 7, 0, 0);  chk("R1 add", res_a, 12); chk("R1 add wr", 32'(wr_a), 1);
    run(1, 5, 7, 0, 0);  chk("R1 sub", res_a, 32'hFFFFFFFE);
    run(3, 5, 7, 1, 0);  chk("R1 addc", res_a, 13);
    run(4, 5, 7, 0, 0);  chk("R1 subb ci0", res_a, 32'hFFFFFFFD);
    run(4, 5, 7, 1, 0);  chk("R1 subb ci1", res_a, 32'hFFFFFFFE);
    chk("R2 wr_b low off dual", 32'(wr_b), 0);
  endtask

  task automatic t_dual;
    run(2, 100, 30, 0, 0);
    chk("R2 sum", res_a, 130); chk("R2 diff", res_b, 70);
    chk("R2 wr_a", 32'(wr_a), 1); chk("R2 wr_b", 32'(wr_b), 1);
  endtask

  task automatic t_avg;
    run(5, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0);
    chk("R3 avg max", res_a, 32'h7FFFFFFF); chk("R3 avg no ov", 32'(flag_v), 0);
    run(5, 32'hFFFFFFFD, 0, 0, 0); chk("R3 avg neg", res_a, 32'hFFFFFFFE);
  endtask

  task automatic t_cmp;
    run(6, 5, 5, 0, 0);  chk("R4 cmp no write", 32'(wr_a), 0); chk("R4 cmp eq z", 32'(flag_z), 1);
    run(6, 3, 5, 0, 0);  chk("R4 cmp lt n", 32'(flag_n), 1); chk("R4 cmp lt z", 32'(flag_z), 0);
    run(25, 3, 5, 0, 0); chk("R4 unused code no write", 32'(wr_a), 0);
  endtask

  task automatic t_unary;
    run(7, 5, 0, 0, 0);             chk("R5 neg", res_a, 32'hFFFFFFFB);
    run(8, 32'hFFFFFFF6, 0, 0, 0);  chk("R5 abs", res_a, 10);
    run(9, 32'h12345678, 0, 0, 0);  chk("R5 pass", res_a, 32'h12345678);
    run(13, 10, 0, 1, 0);           chk("R5 x+ci", res_a, 11);
    run(14, 10, 0, 0, 0);           chk("R5 x+ci-1", res_a, 9);
    run(15, 10, 0, 0, 0);           chk("R5 inc", res_a, 11);
    run(16, 0, 0, 0, 0);            chk("R5 dec", res_a, 32'hFFFFFFFF);
  endtask

  task automatic t_minmax;
    run(10, 32'hFFFFFFFF, 3, 0, 0); chk("R6 min", res_a, 32'hFFFFFFFF);
    run(11, 32'hFFFFFFFF, 3, 0, 0); chk("R6 max", res_a, 3);
  endtask

  task automatic t_clip;
    run(12, 100, 32'hFFFFFFCE, 0, 0);  chk("R7 clip high", res_a, 50);
    run(12, 32'hFFFFFF9C, 50, 0, 0);   chk("R7 clip low", res_a, 32'hFFFFFFCE);
    run(12, 20, 50, 0, 0);             chk("R7 clip inside", res_a, 20);
  endtask

  task automatic t_logic;
    run(17, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 0); chk("R8 and", res_a, 32'h00F000F0);
    run(18, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 0); chk("R8 or", res_a, 32'hFFF0FFF0);
    run(19, 32'hF0F0F0F0, 32'h0FF00FF0, 0, 0); chk("R8 xor", res_a, 32'hFF00FF00);
    run(20, 32'hF0F0F0F0, 0, 0, 0);            chk("R8 not", res_a, 32'h0F0F0F0F);
  endtask

  task automatic t_sat;
    run(0, 32'h7FFFFFFF, 1, 0, 1); chk("R9 add sat", res_a, 32'h7FFFFFFF);
    run(0, 32'h7FFFFFFF, 1, 0, 0); chk("R9 add wrap", res_a, 32'h80000000);
    run(1, 32'h80000000, 1, 0, 1); chk("R9 sub sat", res_a, 32'h80000000);
    run(8, 32'h80000000, 0, 0, 1); chk("R9 abs sat", res_a, 32'h7FFFFFFF);
    run(2, 32'h80000000, 1, 0, 1); chk("R9 dual diff sat", res_b, 32'h80000000);
  endtask

  task automatic t_flags;
    run(0, 32'hFFFFFFFF, 1, 0, 0);
    chk("R10 z", 32'(flag_z), 1); chk("R10 c", 32'(flag_c), 1); chk("R10 v clear", 32'(flag_v), 0);
    run(0, 32'h7FFFFFFF, 1, 0, 0);
    chk("R10 v", 32'(flag_v), 1); chk("R10 n", 32'(flag_n), 1); chk("R10 c clear", 32'(flag_c), 0);
    run(1, 5, 7, 0, 0); chk("R10 borrow c", 32'(flag_c), 0);
    run(1, 7, 5, 0, 0); chk("R10 no borrow c", 32'(flag_c), 1);
  endtask

  task automatic t_sticky;
    run(9, 1, 0, 0, 0); clr_sticky = 1;
    @(posedge clk); #1; clr_sticky = 0;
    chk("R11 cleared", 32'(sticky_v), 0);
    run(0, 32'h7FFFFFFF, 1, 0, 0);
    @(posedge clk); #1; chk("R11 set", 32'(sticky_v), 1);
    run(0, 1, 1, 0, 0);
    @(posedge clk); #1; chk("R11 held", 32'(sticky_v), 1);
    clr_sticky = 1; run(0, 32'h7FFFFFFF, 1, 0, 0);
    @(posedge clk); #1; clr_sticky = 0; chk("R11 set wins over clear", 32'(sticky_v), 1);
    run(9, 1, 0, 0, 0); clr_sticky = 1;
    @(posedge clk); #1; clr_sticky = 0; chk("R11 clear", 32'(sticky_v), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    t_reset; t_arith; t_dual; t_avg; t_cmp; t_unary; t_minmax;
    t_clip; t_logic; t_sat; t_flags; t_sticky;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule